// File: doc/BRIEF.md
# Global Performance Counter Control with Overflow Freeze

This block holds the central 64-bit control word for a group of performance counters. It drives one global enable to every counter, and it collects the single-cycle overflow pulses that the counters send back. It can also drop the global enable by itself when an overflow arrives, so that all counters stop at the same moment. Software sets the enable, the freeze option, the wake option and a mask of target cores through a plain write port, and reads the word back the same way.

When an overflow is accepted, a small sequencer for each selected core turns it into a one-cycle interrupt request for that core. If the wake option is on and the core reports itself halted, the sequencer first raises a wake request. It holds that request until the core leaves the halted state, and only then sends the interrupt. An overflow that arrives while a sequencer is busy is kept as a single pending event and is delivered when the current sequence ends.

Top module: `pgc_top`

## Requirements
- R1: After reset the control word reads zero, and the global enable, wake requests and interrupt requests are all low.
- R2: Only bits 3:0 (core select, bit n = core n), bit 29 (enable), bit 30 (wake option) and bit 31 (freeze) can be written. All other bits read zero and ignore writes. Readback is 0xE000000F after writing all ones.
- R3: `global_en_o` follows bit 29 and takes a written value in the cycle after the write.
- R4: If bit 31 and bit 29 are both set and any bit of `ovf_i` is high, bit 29 reads zero in the next cycle and the other fields keep their values.
- R5: A hardware clear caused by freeze wins over a software write of 1 to bit 29 in the same cycle.
- R6: With bit 31 clear, an overflow leaves bit 29 set.
- R7: Overflow pulses that arrive while bit 29 is clear cause no wake request and no interrupt, then or later.
- R8: With the wake option off, or with the core not halted, every selected core gets an interrupt request that lasts exactly one cycle. It comes in the cycle after the overflow is sampled. Cores that are not selected get none.
- R9: With the wake option on and a selected core halted, `wake_req_o` for that core is high from the cycle after the overflow until halted is sampled low. The interrupt follows in the next cycle, and wake and interrupt are never high together.
- R10: Overflows that arrive while a core's sequencer is busy merge into one pending event. That event gives exactly one more interrupt, two cycles after the current one.
- R11: With the wake option off, a halted selected core gets its interrupt directly, with no wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Current control word |
| ovf_i | input | NUM_CNT | Overflow pulses from the counters |
| halted_i | input | NUM_CORES | Per-core halted status |
| global_en_o | output | 1 | Global counter enable |
| wake_req_o | output | NUM_CORES | Per-core wake request |
| irq_o | output | NUM_CORES | Per-core single-cycle interrupt request |

## Verification
The checker watches on every cycle that freeze drops the enable after an accepted overflow, even when a write of 1 to the enable lands in the same cycle. It also checks that a write without freeze sets the enable to the written value, that an interrupt pulse never lasts two cycles, that wake and interrupt never overlap, and that a wake request whose core has woken is followed by the interrupt. Some behaviours show up only in the bench's scenarios, because they need a sequence of events. These are the masking of reserved bits, the ignoring of overflows while disabled, the per-core select mask, and the merging of several overflows during a busy sequence into exactly one extra interrupt.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int REG_W    = 64;
  localparam int SEL_LSB  = 0;
  localparam int EN_BIT   = 29;
  localparam int WAKE_BIT = 30;
  localparam int FRZ_BIT  = 31;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAKE = 2'd1,
    SEQ_FIRE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pgc_ctrl_reg.sv
module pgc_ctrl_reg
  import pgc_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_W-1:0]     wr_data_i,
  input  logic                 hw_clr_i,
  output logic [NUM_CORES-1:0] sel_o,
  output logic                 en_o,
  output logic                 wake_o,
  output logic                 frz_o,
  output logic [REG_W-1:0]     rd_data_o
);
  localparam int SEL_MSB = SEL_LSB + NUM_CORES - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= '0;
      wake_o <= 1'b0;
      frz_o  <= 1'b0;
    end else if (wr_en_i) begin
      sel_o  <= wr_data_i[SEL_MSB:SEL_LSB];
      wake_o <= wr_data_i[WAKE_BIT];
      frz_o  <= wr_data_i[FRZ_BIT];
    end
  end

  // hardware freeze clear wins over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= 1'b0;
    else if (hw_clr_i) en_o <= 1'b0;
    else if (wr_en_i)  en_o <= wr_data_i[EN_BIT];
  end

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[SEL_MSB:SEL_LSB] = sel_o;
    rd_data_o[EN_BIT]          = en_o;
    rd_data_o[WAKE_BIT]        = wake_o;
    rd_data_o[FRZ_BIT]         = frz_o;
  end
endmodule

// File: rtl/pgc_ovf_gate.sv
module pgc_ovf_gate #(
  parameter int NUM_CNT = 8
) (
  input  logic               en_i,
  input  logic               frz_i,
  input  logic [NUM_CNT-1:0] ovf_i,
  output logic               hit_o,
  output logic               clr_o
);
  assign hit_o = en_i & (|ovf_i);
  assign clr_o = hit_o & frz_i;
endmodule

// File: rtl/pgc_core_seq.sv
module pgc_core_seq
  import pgc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic wake_en_i,
  input  logic halted_i,
  output logic wake_req_o,
  output logic irq_o
);
  seq_state_e state_q, state_d;
  logic       pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (trig_i || pend_q) begin
          pend_d  = 1'b0;
          state_d = (wake_en_i && halted_i) ? SEQ_WAKE : SEQ_FIRE;
        end
      end
      SEQ_WAKE: begin
        if (trig_i) pend_d = 1'b1;
        if (!halted_i) state_d = SEQ_FIRE;
      end
      SEQ_FIRE: begin
        if (trig_i) pend_d = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign wake_req_o = (state_q == SEQ_WAKE);
  assign irq_o      = (state_q == SEQ_FIRE);
endmodule

// File: rtl/pgc_top.sv
module pgc_top
  import pgc_pkg::*;
#(
  parameter int NUM_CNT   = 8,
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [63:0]          wr_data_i,
  output logic [63:0]          rd_data_o,
  input  logic [NUM_CNT-1:0]   ovf_i,
  input  logic [NUM_CORES-1:0] halted_i,
  output logic                 global_en_o,
  output logic [NUM_CORES-1:0] wake_req_o,
  output logic [NUM_CORES-1:0] irq_o
);
  logic [NUM_CORES-1:0] sel;
  logic                 wake_en, frz, ovf_hit, hw_clr;

  pgc_ctrl_reg #(.NUM_CORES(NUM_CORES)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .hw_clr_i  (hw_clr),
    .sel_o     (sel),
    .en_o      (global_en_o),
    .wake_o    (wake_en),
    .frz_o     (frz),
    .rd_data_o (rd_data_o)
  );

  pgc_ovf_gate #(.NUM_CNT(NUM_CNT)) u_gate (
    .en_i  (global_en_o),
    .frz_i (frz),
    .ovf_i (ovf_i),
    .hit_o (ovf_hit),
    .clr_o (hw_clr)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    pgc_core_seq u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trig_i     (ovf_hit & sel[c]),
      .wake_en_i  (wake_en),
      .halted_i   (halted_i[c]),
      .wake_req_o (wake_req_o[c]),
      .irq_o      (irq_o[c])
    );
  end
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
  parameter int NUM_CNT   = 8,
  parameter int NUM_CORES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [63:0]          wr_data_i,
  input logic [63:0]          rd_data_o,
  input logic [NUM_CNT-1:0]   ovf_i,
  input logic [NUM_CORES-1:0] halted_i,
  input logic                 global_en_o,
  input logic [NUM_CORES-1:0] wake_req_o,
  input logic [NUM_CORES-1:0] irq_o
);
  logic frz_hit;
  assign frz_hit = rd_data_o[31] && global_en_o && (|ovf_i);

  assert_freeze_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_hit |=> !global_en_o);

  assert_hw_clear_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_hit && wr_en_i && wr_data_i[29]) |=> !global_en_o);

  assert_write_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !frz_hit) |=> (global_en_o == $past(wr_data_i[29])));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |=> !irq_o[c]);
    assert_wake_irq_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(irq_o[c] && wake_req_o[c]));
    assert_wake_then_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_req_o[c] && !halted_i[c]) |=> irq_o[c]);
  end
endmodule

bind pgc_top pgc_checker #(.NUM_CNT(NUM_CNT), .NUM_CORES(NUM_CORES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .ovf_i       (ovf_i),
  .halted_i    (halted_i),
  .global_en_o (global_en_o),
  .wake_req_o  (wake_req_o),
  .irq_o       (irq_o)
);

// File: tb/pgc_top_tb.sv
module pgc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCNT = 8;
  localparam int NCORE = 4;
  localparam logic [63:0] WMASK = 64'h0000_0000_E000_000F;
  localparam logic [63:0] B_EN = 64'h2000_0000;
  localparam logic [63:0] B_WK = 64'h4000_0000;
  localparam logic [63:0] B_FZ = 64'h8000_0000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [63:0]      wr_data = '0;
  logic [63:0]      rd_data;
  logic [NCNT-1:0]  ovf = '0;
  logic [NCORE-1:0] halted = '0;
  logic             gen;
  logic [NCORE-1:0] wake, irq;
  int               n_chk = 0;
  int               n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgc_top #(.NUM_CNT(NCNT), .NUM_CORES(NCORE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ovf_i(ovf), .halted_i(halted),
    .global_en_o(gen), .wake_req_o(wake), .irq_o(irq)
  );

  function automatic logic [63:0] exp_rd(logic [63:0] d);
    return d & WMASK;
  endfunction

  function automatic logic [63:0] exp_next(logic [63:0] cur, logic we, logic [63:0] d, logic [NCNT-1:0] o);
    logic [63:0] n;
    logic clr;
    clr = cur[31] && cur[29] && (|o);
    n = we ? exp_rd(d) : cur;
    if (clr) n[29] = 1'b0;
    return n;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [63:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic drain();
    ovf = '0; halted = '0;
    wr(64'h0);
    step(); step(); step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] model;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd", rd_data, 64'h0);
    chk("R1 en", {63'h0, gen}, 64'h0);
    chk("R1 wake", {60'h0, wake}, 64'h0);
    chk("R1 irq", {60'h0, irq}, 64'h0);
    rst_n = 1'b1;
    step();
    chk("R1 rd after release", rd_data, 64'h0);

    // R2 / R3 writes
    wr('1);
    chk("R2 all ones", rd_data, WMASK);
    chk("R3 en set", {63'h0, gen}, 64'h1);
    wr(64'h0);
    chk("R3 en clear", {63'h0, gen}, 64'h0);
    for (int i = 0; i < 40; i++) begin
      logic [63:0] d;
      d = {$urandom(), $urandom()};
      d[31] = 1'b0;
      wr(d);
      chk("R2 random readback", rd_data, exp_rd(d));
      chk("R3 random enable", {63'h0, gen}, {63'h0, d[29]});
    end
    drain();

    // R4 freeze clears enable, other fields kept
    wr(B_FZ | B_EN | 64'h0);
    ovf = 8'h10;
    step();
    ovf = '0;
    chk("R4 freeze clear", rd_data, B_FZ);
    chk("R4 en low", {63'h0, gen}, 64'h0);
    drain();

    // R5 hw clear beats same-cycle write
    wr(B_FZ | B_EN);
    ovf = 8'h01; wr_en = 1'b1; wr_data = B_FZ | B_EN;
    step();
    wr_en = 1'b0; ovf = '0;
    chk("R5 clear wins", {63'h0, gen}, 64'h0);
    drain();

    // R6 no freeze keeps enable
    wr(B_EN);
    ovf = 8'hFF;
    step();
    ovf = '0;
    chk("R6 en kept", {63'h0, gen}, 64'h1);
    drain();

    // R7 overflow ignored while disabled
    wr(B_WK | 64'hF);
    halted = 4'h3;
    ovf = 8'h81;
    step();
    ovf = '0;
    chk("R7 no irq", {60'h0, irq}, 64'h0);
    chk("R7 no wake", {60'h0, wake}, 64'h0);
    halted = '0;
    wr(B_EN | 64'hF);
    step();
    chk("R7 no late irq", {60'h0, irq}, 64'h0);
    step();
    chk("R7 no late irq 2", {60'h0, irq}, 64'h0);
    drain();

    // R8 select mask, single cycle
    wr(B_EN | 64'h5);
    ovf = 8'h02;
    step();
    ovf = '0;
    chk("R8 irq selected", {60'h0, irq}, 64'h5);
    step();
    chk("R8 irq one cycle", {60'h0, irq}, 64'h0);
    drain();

    // R9 wake before interrupt
    wr(B_EN | B_WK | 64'h1);
    halted = 4'h1;
    ovf = 8'h04;
    step();
    ovf = '0;
    chk("R9 wake raised", {60'h0, wake}, 64'h1);
    chk("R9 no irq yet", {60'h0, irq}, 64'h0);
    step();
    chk("R9 wake held", {60'h0, wake}, 64'h1);
    halted = '0;
    step();
    chk("R9 wake dropped", {60'h0, wake}, 64'h0);
    chk("R9 irq after wake", {60'h0, irq}, 64'h1);
    step();
    chk("R9 irq ends", {60'h0, irq}, 64'h0);
    drain();

    // R11 no wake option, halted core gets irq directly
    wr(B_EN | 64'h2);
    halted = 4'h2;
    ovf = 8'h08;
    step();
    ovf = '0;
    chk("R11 direct irq", {60'h0, irq}, 64'h2);
    chk("R11 no wake", {60'h0, wake}, 64'h0);
    drain();

    // R10 pending during busy, merged
    wr(B_EN | B_WK | 64'h1);
    halted = 4'h1;
    ovf = 8'h01;
    step();
    chk("R10 in wake", {60'h0, wake}, 64'h1);
    step(); step();
    ovf = '0;
    halted = '0;
    step();
    chk("R10 first irq", {60'h0, irq}, 64'h1);
    step();
    chk("R10 gap", {60'h0, irq}, 64'h0);
    step();
    chk("R10 pending irq", {60'h0, irq}, 64'h1);
    step();
    chk("R10 no third a", {60'h0, irq}, 64'h0);
    step();
    chk("R10 no third b", {60'h0, irq}, 64'h0);
    drain();

    // R4/R5/R6 random freeze traffic
    model = '0;
    for (int i = 0; i < 80; i++) begin
      logic we;
      logic [63:0] d;
      logic [NCNT-1:0] o;
      we = ($urandom() % 3) == 0;
      d = {$urandom(), $urandom()};
      o = (($urandom() % 2) == 0) ? NCNT'($urandom()) : '0;
      wr_en = we; wr_data = d; ovf = o;
      model = exp_next(model, we, d, o);
      step();
      chk("R4 random freeze model", rd_data, model);
    end
    wr_en = 1'b0; ovf = '0;
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule